// File: doc/BRIEF.md
# Prime Sequence Counter with Pass Limit

This block is a synchronous counter that visits only the prime numbers that fit in an unsigned word of `VAL_W` bits. With the default width of 6 bits it presents 2, 3, 5, … 61, one value for each enabled clock edge. After the largest prime it returns to the smallest one and starts a new pass.

After `PASSES` complete passes (5 by default) it stops. It raises a done flag, drops its valid strobe and freezes its value until the next reset.

All state sits in explicit flip-flop banks. The next value comes from constant-derived AND-OR match logic or from a lookup mux; the `NEXT_IMPL` parameter chooses between them. No arithmetic increment is used. The pass count is kept in a one-hot ring, not an adder.

Top module: `prime_seq_counter`

## Requirements
- R1: While valid is high, value is always a prime (a natural number above 1 whose only divisors are 1 and itself) below 2**VAL_W; 0 and 1 never appear. The default width is 6 bits, so the values lie in 2..61.
- R2: A synchronous reset (rst high at a clock edge) makes value 2, done 0 and valid 1 on the cycle after that edge.
- R3: On a clock edge with en high, valid high and value below the largest prime, value becomes the next larger prime on the following cycle, and valid stays high.
- R4: On a clock edge with en high and value equal to the largest prime (61 by default), value returns to 2 on the following cycle unless that edge ends the final pass.
- R5: On a clock edge with en low, value, valid and done keep their values.
- R6: The enabled edge at the largest prime during pass number PASSES (5 by default) sets done to 1 and valid to 0 and leaves value at the largest prime. From then on, value, valid and done hold at every edge, whatever en is, until reset.
- R7: With en held high from reset, exactly 18 × PASSES cycles (90 by default) show valid high before done rises.
- R8: A reset in the middle of a run discards the progress already made, and the full set of PASSES passes runs again from value 2.
- R9: Both next-value variants (NEXT_IMPL 1 = prime-match AND-OR network, NEXT_IMPL 0 = full lookup mux) produce the same output stream for the same input stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; while low, all state holds |
| value | output | VAL_W | Current prime of the sequence |
| valid | output | 1 | High while value belongs to a pass still in progress |
| done | output | 1 | High once all passes have completed |

## Verification
The stream is first driven with en held high. This separates correct prime stepping and wrap-around from any skip or repeat, and it pins the exact edge at which done rises against the count of 90.

A long, irregular en pattern (two edges on, one edge off) then checks that holding is independent of where in the sequence the pause lands. It also checks that a pause just before the largest prime does not disturb the wrap or the pass count.

After done, en is toggled to show that the frozen state ignores it. A reset in the middle of a run shows that the pass count restarts rather than resuming. Two instances with different next-value variants are compared edge by edge, and every valid output is also checked with a software trial-division test.

// File: rtl/prime_seq_pkg.sv
package prime_seq_pkg;

   // Trial division; usable both at elaboration and at run time.
   function automatic bit is_prime(input int n);
      bit r;
      r = (n >= 2);
      for (int d = 2; d * d <= n; d++) begin
         if (n % d == 0) r = 1'b0;
      end
      return r;
   endfunction

   // Number of primes below 2**w.
   function automatic int prime_count(input int w);
      int c;
      c = 0;
      for (int n = 0; n < (1 << w); n++) begin
         if (is_prime(n)) c++;
      end
      return c;
   endfunction

   // The k-th prime (k from 0) below 2**w, or 0 when out of range.
   function automatic int prime_at(input int w, input int k);
      int c;
      int r;
      c = 0;
      r = 0;
      for (int n = 0; n < (1 << w); n++) begin
         if (is_prime(n)) begin
            if (c == k) r = n;
            c++;
         end
      end
      return r;
   endfunction

   // Smallest prime above v below 2**w; wraps to the first prime.
   function automatic int next_after(input int w, input int v);
      int r;
      bit found;
      r = prime_at(w, 0);
      found = 1'b0;
      for (int n = v + 1; n < (1 << w); n++) begin
         if (!found && is_prime(n)) begin
            r = n;
            found = 1'b1;
         end
      end
      return r;
   endfunction

endpackage

// File: rtl/prime_seq_flops.sv
module prime_seq_flops #(
   parameter int         W    = 1,
   parameter logic [W-1:0] INIT = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         ld,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_w
      $error("prime_seq_flops: W must be at least 1");
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      logic r;
      always_ff @(posedge clk) begin
         if (rst)     r <= INIT[b];
         else if (ld) r <= d[b];
      end
      assign q[b] = r;
   end

endmodule

// File: rtl/prime_next_logic.sv
module prime_next_logic
   import prime_seq_pkg::*;
#(
   parameter int VAL_W     = 6,
   parameter int NEXT_IMPL = 1
) (
   input  logic [VAL_W-1:0] cur,
   output logic [VAL_W-1:0] nxt
);

   localparam int SPAN = 1 << VAL_W;
   localparam int NP   = prime_count(VAL_W);

   if (NEXT_IMPL == 0) begin : g_table
      // Full lookup: one constant entry per possible value.
      logic [VAL_W-1:0] tbl [SPAN];
      for (genvar i = 0; i < SPAN; i++) begin : g_ent
         assign tbl[i] = VAL_W'(next_after(VAL_W, i));
      end
      assign nxt = tbl[cur];
   end else begin : g_match
      // One equality detector per prime; each gates its successor
      // onto a shared OR plane.
      logic [NP-1:0]    hit;
      logic [VAL_W-1:0] term [NP];
      for (genvar k = 0; k < NP; k++) begin : g_p
         localparam int PK = prime_at(VAL_W, k);
         localparam int PN = prime_at(VAL_W, (k + 1) % NP);
         assign hit[k]  = (cur == VAL_W'(PK));
         assign term[k] = {VAL_W{hit[k]}} & VAL_W'(PN);
      end
      always_comb begin
         nxt = '0;
         for (int k = 0; k < NP; k++) nxt = nxt | term[k];
      end
   end

endmodule

// File: rtl/prime_pass_ring.sv
module prime_pass_ring #(
   parameter int PASSES = 5
) (
   input  logic clk,
   input  logic rst,
   input  logic adv,
   output logic final_pass
);

   localparam logic [PASSES-1:0] START = PASSES'(1);

   logic [PASSES-1:0] ring_q;
   logic [PASSES-1:0] ring_d;

   if (PASSES == 1) begin : g_single
      assign ring_d = ring_q;
   end else begin : g_rot
      assign ring_d = {ring_q[PASSES-2:0], ring_q[PASSES-1]};
   end

   prime_seq_flops #(.W(PASSES), .INIT(START)) u_ring (
      .clk (clk),
      .rst (rst),
      .ld  (adv),
      .d   (ring_d),
      .q   (ring_q)
   );

   assign final_pass = ring_q[PASSES-1];

endmodule

// File: rtl/prime_seq_counter.sv
module prime_seq_counter
   import prime_seq_pkg::*;
#(
   parameter int VAL_W     = 6,
   parameter int PASSES    = 5,
   parameter int NEXT_IMPL = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   output logic [VAL_W-1:0] value,
   output logic             valid,
   output logic             done
);

   localparam int NP = prime_count(VAL_W);
   localparam logic [VAL_W-1:0] FIRST = VAL_W'(prime_at(VAL_W, 0));
   localparam logic [VAL_W-1:0] LAST  = VAL_W'(prime_at(VAL_W, NP - 1));

   if (VAL_W < 2 || VAL_W > 10) begin : g_bad_w
      $error("prime_seq_counter: VAL_W must lie in 2..10");
   end
   if (PASSES < 1) begin : g_bad_p
      $error("prime_seq_counter: PASSES must be at least 1");
   end
   if (NEXT_IMPL != 0 && NEXT_IMPL != 1) begin : g_bad_i
      $error("prime_seq_counter: NEXT_IMPL must be 0 or 1");
   end

   logic [VAL_W-1:0] val_q;
   logic [VAL_W-1:0] val_nxt;
   logic             done_q;
   logic             final_pass;
   logic             step;
   logic             at_last;
   logic             wrap;
   logic             finish;

   assign step    = en & ~done_q;
   assign at_last = (val_q == LAST);
   assign wrap    = step & at_last;
   assign finish  = wrap & final_pass;

   prime_next_logic #(.VAL_W(VAL_W), .NEXT_IMPL(NEXT_IMPL)) u_next (
      .cur (val_q),
      .nxt (val_nxt)
   );

   prime_seq_flops #(.W(VAL_W), .INIT(FIRST)) u_val (
      .clk (clk),
      .rst (rst),
      .ld  (step & ~finish),
      .d   (val_nxt),
      .q   (val_q)
   );

   prime_pass_ring #(.PASSES(PASSES)) u_pass (
      .clk        (clk),
      .rst        (rst),
      .adv        (wrap & ~final_pass),
      .final_pass (final_pass)
   );

   prime_seq_flops #(.W(1), .INIT(1'b0)) u_done (
      .clk (clk),
      .rst (rst),
      .ld  (finish),
      .d   (1'b1),
      .q   (done_q)
   );

   assign value = val_q;
   assign done  = done_q;
   assign valid = ~done_q;

endmodule

// File: rtl/prime_seq_checker.sv
module prime_seq_checker
   import prime_seq_pkg::*;
#(
   parameter int VAL_W = 6
) (
   input logic             clk,
   input logic             rst,
   input logic             en,
   input logic [VAL_W-1:0] value,
   input logic             valid,
   input logic             done
);

   localparam int NP = prime_count(VAL_W);
   localparam logic [VAL_W-1:0] FIRST = VAL_W'(prime_at(VAL_W, 0));
   localparam logic [VAL_W-1:0] LAST  = VAL_W'(prime_at(VAL_W, NP - 1));

   AST_ONLY_PRIMES: assert property (@(posedge clk) disable iff (rst)
      valid |-> is_prime(int'(value))); // R1

   AST_ADVANCE_UP: assert property (@(posedge clk) disable iff (rst)
      (en && valid && value != LAST) |=> (valid && value > $past(value))); // R3

   AST_WRAP_OR_END: assert property (@(posedge clk) disable iff (rst)
      (en && valid && value == LAST) |=> (value == FIRST || (done && value == LAST))); // R4

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !en |=> ($stable(value) && $stable(done))); // R5

   AST_DONE_FROZEN: assert property (@(posedge clk) disable iff (rst)
      done |=> (done && !valid && value == $past(value))); // R6

endmodule

bind prime_seq_counter prime_seq_checker #(.VAL_W(VAL_W)) u_chk (
   .clk   (clk),
   .rst   (rst),
   .en    (en),
   .value (value),
   .valid (valid),
   .done  (done)
);

// File: tb/sim_prime_seq_counter.sv
`timescale 1ns/1ps
module sim_prime_seq_counter;

   localparam int W      = 6;
   localparam int P      = 5;
   localparam int TOP    = 64;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic en  = 1'b0;

   logic [W-1:0] value0, value1;
   logic         valid0, valid1, done0, done1;

   int tests = 0;
   int fails = 0;
   int e_val, e_pass, e_last, vcount;
   bit e_done;

   always #5 clk = ~clk;

   prime_seq_counter #(.VAL_W(W), .PASSES(P), .NEXT_IMPL(1)) u0 (
      .clk(clk), .rst(rst), .en(en), .value(value0), .valid(valid0), .done(done0));

   prime_seq_counter #(.VAL_W(W), .PASSES(P), .NEXT_IMPL(0)) u1 (
      .clk(clk), .rst(rst), .en(en), .value(value1), .valid(valid1), .done(done1));

   function automatic bit sw_prime(input int n);
      if (n < 2) return 1'b0;
      for (int d = 2; d < n; d++) if (n % d == 0) return 1'b0;
      return 1'b1;
   endfunction

   function automatic int sw_next(input int v);
      int n;
      n = v + 1;
      while (n < TOP && !sw_prime(n)) n++;
      if (n >= TOP) n = 2;
      return n;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic do_reset(input string req);
      rst = 1'b1;
      en  = 1'b0;
      @(posedge clk);
      @(posedge clk);
      #1;
      rst = 1'b0;
      e_val = 2; e_pass = 0; e_done = 1'b0;
      chk(value0 == 2, req, "reset value", int'(value0), 2);
      chk(valid0 == 1'b1, req, "reset valid", int'(valid0), 1);
      chk(done0 == 1'b0, req, "reset done", int'(done0), 0);
   endtask

   task automatic step(input bit e);
      string tag;
      if (e_done)            tag = "R6";
      else if (!e)           tag = "R5";
      else if (e_val == e_last) tag = "R4";
      else                   tag = "R3";
      if (e && !e_done) begin
         vcount++;
         if (e_val == e_last) begin
            if (e_pass == P - 1) e_done = 1'b1;
            else begin e_pass++; e_val = 2; end
         end else begin
            e_val = sw_next(e_val);
         end
      end
      en = e;
      @(posedge clk);
      #1;
      chk(int'(value0) == e_val, tag, "value", int'(value0), e_val);
      chk(done0 == e_done, tag, "done", int'(done0), int'(e_done));
      chk(valid0 == !e_done, tag, "valid", int'(valid0), int'(!e_done));
      chk(value1 == value0 && done1 == done0 && valid1 == valid0, "R9",
          "variant match value", int'(value1), int'(value0));
      if (valid0) chk(sw_prime(int'(value0)), "R1", "primality", int'(value0), e_val);
   endtask

   initial begin
      e_last = 2;
      for (int n = 2; n < TOP; n++) if (sw_prime(n)) e_last = n;

      do_reset("R2");
      for (int i = 0; i < 40; i++) step(1'b1);
      for (int i = 0; i < 8; i++) step(1'b0);
      for (int i = 0; i < 600 && !e_done; i++) step(i % 3 != 0);
      chk(done0 == 1'b1, "R6", "done after gapped run", int'(done0), 1);
      for (int i = 0; i < 6; i++) step(1'b1);
      for (int i = 0; i < 6; i++) step(i % 2 == 0);
      chk(int'(value0) == e_last, "R6", "frozen value", int'(value0), e_last);

      do_reset("R2");
      for (int i = 0; i < 30; i++) step(1'b1);
      do_reset("R8");
      vcount = 0;
      for (int i = 0; i < 200 && !done0; i++) step(1'b1);
      chk(vcount == 18 * P, "R7", "valid cycles before done", vcount, 18 * P);
      chk(done0 == 1'b1, "R8", "full run after mid reset", int'(done0), 1);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #2000000;
      fails++;
      $display("FAIL R7 watchdog: got %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule